// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps the time of day and the calendar for a byte-wide memory-mapped bus. A counter chain holds seconds, minutes, hours, day of week, date, month and year as packed BCD. It advances once for every pulse on a one-per-second tick input. Date rollover follows the length of each month, and February gets 29 days in leap years. The eight byte registers sit at the eight highest addresses of the bus address space. Seven of them hold time fields and one is a control register.

Software reads a separate visible copy of the time fields rather than the live counters. While the control register's freeze bit is set, that copy holds still and the counters keep running underneath, so a multi-byte read is always coherent and no time is lost. When the bit is cleared, every visible field reloads from the counters at the same clock edge. A power-fail input cuts the block off from the bus: writes are dropped and no read data is driven.

Top module: `rtc_dbuf_clock`

## Requirements
- R1: Register offsets, taken from the low three address bits when all higher address bits are 1, are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. After reset the fields read 00:00:00, day 1, date 01, month 01, year 00, and control reads 0x00.
- R2: Seconds and minutes count 00–59 and hours count 00–23 in packed BCD (tens in bits 7:4, units in bits 3:0). Each field carries into the next one when it wraps.
- R3: The date wraps to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, after day 30 in months 04, 06, 09 and 11, and in month 02 after day 29 when the year is a multiple of 4 and after day 28 otherwise. The month wraps from 12 to 01 and the year wraps from 99 to 00.
- R4: Day of week counts 1–7, advances when the hours wrap, and goes from 7 back to 1.
- R5: While control bit 6 (freeze) is 1, the visible time fields keep the values they had when the bit was written. The only exception is a field that is itself written. Control reads back 0x40 while frozen, and all its other bits read 0.
- R6: The internal counters keep counting on every tick while frozen.
- R7: When freeze is cleared, all seven visible fields show the current count from the next clock edge on. This also holds when a tick arrives in the same cycle as the clear.
- R8: While pwr_fail is 1, bus writes change nothing, rdata_oe stays 0 and rdata is 0x00.
- R9: A write to a time field loads both the counter and the visible copy. If a tick lands in the same cycle, the written value wins for that field, and the tick's carry into higher fields still applies.
- R10: A single tick carries through every field, so 23:59:59 on 31-12-99 becomes 00:00:00 on 01-01-00.
- R11: A read (cs=1, we=0) returns its data with rdata_oe=1 on the cycle after the request. An address outside the top eight returns rdata_oe=0 and rdata=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| pwr_fail | input | 1 | Supply out of tolerance; isolates the bus |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable (1 = write) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, 0 when not driven |
| rdata_oe | output | 1 | Read data valid/drive enable |

## Verification
The functions that collide are the per-second tick and the bus. One case is a tick arriving in the same cycle as a time-field write. The other is a tick arriving in the same cycle as the write that clears freeze. The bench drives tick and the write together in one cycle, with the seconds at 59 so the carry is live. A behavioural model updated on every edge predicts which field takes the written value, where the carry goes, and that the reloaded visible copy already includes the tick. Every read is judged against that prediction.

// File: rtl/rtc_pkg.sv
// Package: shared field indices, types and BCD helpers for the calendar clock.
// Assumes all stored values are valid packed BCD.
package rtc_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int FLD_SEC    = 0;
    localparam int FLD_MIN    = 1;
    localparam int FLD_HOUR   = 2;
    localparam int FLD_DOW    = 3;
    localparam int FLD_DATE   = 4;
    localparam int FLD_MON    = 5;
    localparam int FLD_YEAR   = 6;
    localparam int FREEZE_BIT = 6;

    typedef logic [7:0] bcd8_t;
    typedef logic [NUM_FIELDS-1:0][7:0] time_vec_t;

    // Increment a two-digit BCD value (no wrap handling).
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year multiple of four, judged from its BCD digits.
    function automatic logic is_leap(input bcd8_t y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last date of a month in BCD.
    function automatic bcd8_t month_len(input bcd8_t mon, input bcd8_t yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Lowest value (and reset value) of each field.
    function automatic bcd8_t field_min(input int idx);
        case (idx)
            FLD_DOW, FLD_DATE, FLD_MON: return 8'h01;
            default:                    return 8'h00;
        endcase
    endfunction

    // Fixed top value of each field; the date's top is computed elsewhere.
    function automatic bcd8_t field_max(input int idx);
        case (idx)
            FLD_SEC, FLD_MIN: return 8'h59;
            FLD_HOUR:         return 8'h23;
            FLD_DOW:          return 8'h07;
            FLD_MON:          return 8'h12;
            FLD_YEAR:         return 8'h99;
            default:          return 8'h31;
        endcase
    endfunction

    // Bits that a field actually stores; others read as 0.
    function automatic bcd8_t field_mask(input int idx);
        case (idx)
            FLD_SEC, FLD_MIN:   return 8'h7F;
            FLD_HOUR, FLD_DATE: return 8'h3F;
            FLD_DOW:            return 8'h07;
            FLD_MON:            return 8'h1F;
            default:            return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/rtc_field_counter.sv
// One BCD counter field of the time chain. Counts MIN_VAL..max_val and
// raises carry when it wraps. A load overrides the count. The carry depends
// only on the increment and the old value, so a load does not swallow it.
module rtc_field_counter
    import rtc_pkg::*;
#(
    parameter bcd8_t MIN_VAL = 8'h00,
    parameter bcd8_t MASK    = 8'hFF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc,
    input  logic  ld,
    input  bcd8_t ld_val,
    input  bcd8_t max_val,
    output bcd8_t value,
    output bcd8_t nxt,
    output logic  carry
);

    logic at_top;

    // Wrap detect and next-value selection.
    always_comb begin
        at_top = (value == max_val);
        carry  = inc && at_top;
        if (ld)       nxt = ld_val & MASK;
        else if (inc) nxt = at_top ? MIN_VAL : bcd_inc(value);
        else          nxt = value;
    end

    // Field state register.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= MIN_VAL;
        else        value <= nxt;
    end

endmodule

// File: rtl/rtc_time_chain.sv
// Internal counter chain: seconds through year, advanced by tick. All
// carries resolve combinationally within the ticking cycle. The date limit
// comes from the current month and year.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [NUM_FIELDS-1:0] ld_en,
    input  bcd8_t                 ld_val,
    output time_vec_t             cur,
    output time_vec_t             nxt
);

    logic [NUM_FIELDS-1:0] inc;
    logic [NUM_FIELDS-1:0] carry;
    time_vec_t             max_v;

    // Carry routing between fields.
    always_comb begin
        inc           = '0;
        inc[FLD_SEC]  = tick;
        inc[FLD_MIN]  = carry[FLD_SEC];
        inc[FLD_HOUR] = carry[FLD_MIN];
        inc[FLD_DOW]  = carry[FLD_HOUR];
        inc[FLD_DATE] = carry[FLD_HOUR];
        inc[FLD_MON]  = carry[FLD_DATE];
        inc[FLD_YEAR] = carry[FLD_MON];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
            if (gi == FLD_DATE) begin : g_var
                // Month-length dependent top.
                always_comb max_v[gi] = month_len(cur[FLD_MON], cur[FLD_YEAR]);
            end else begin : g_fix
                // Fixed top value.
                always_comb max_v[gi] = field_max(gi);
            end
            rtc_field_counter #(
                .MIN_VAL (field_min(gi)),
                .MASK    (field_mask(gi))
            ) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (inc[gi]),
                .ld      (ld_en[gi]),
                .ld_val  (ld_val),
                .max_val (max_v[gi]),
                .value   (cur[gi]),
                .nxt     (nxt[gi]),
                .carry   (carry[gi])
            );
        end
    endgenerate

endmodule

// File: rtl/rtc_shadow_regs.sv
// Visible copy of the time fields. While unfrozen it follows the counters'
// next state, so it equals the count on every cycle. While frozen it holds,
// except for fields written over the bus.
module rtc_shadow_regs
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  freeze,
    input  logic [NUM_FIELDS-1:0] ld_en,
    input  bcd8_t                 ld_val,
    input  time_vec_t             cnt_nxt,
    output time_vec_t             vis
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_vis
            // Per-field visible register with freeze/hold.
            always_ff @(posedge clk) begin
                if (!rst_n)          vis[gi] <= field_min(gi);
                else if (!freeze)    vis[gi] <= cnt_nxt[gi];
                else if (ld_en[gi])  vis[gi] <= ld_val & field_mask(gi);
            end
        end
    endgenerate

endmodule

// File: rtl/rtc_bus_port.sv
// Bus front end: decodes the top eight addresses, gates everything with
// power-fail and registers the read data one cycle after the request.
module rtc_bus_port
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_fail,
    input  logic                  cs,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  time_vec_t             vis,
    input  logic                  freeze,
    output logic [NUM_FIELDS-1:0] time_ld,
    output logic                  ctrl_wr,
    output bcd8_t                 rdata,
    output logic                  rdata_oe
);

    localparam int OFF_W = 3;

    logic             hit;
    logic             access;
    logic [OFF_W-1:0] off;
    bcd8_t            rd_mux;

    // Address decode and access qualification.
    always_comb begin
        hit     = &addr[ADDR_W-1:OFF_W];
        off     = addr[OFF_W-1:0];
        access  = cs && hit && !pwr_fail;
        ctrl_wr = access && we && (off == '0);
        for (int i = 0; i < NUM_FIELDS; i++)
            time_ld[i] = access && we && (int'(off) == i + 1);
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        if (off == '0) rd_mux[FREEZE_BIT] = freeze;
        else           rd_mux = vis[off - 3'd1];
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else if (access && !we) begin
            rdata    <= rd_mux;
            rdata_oe <= 1'b1;
        end else begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_dbuf_clock.sv
// Top: memory-mapped BCD calendar clock with a freezable visible copy.
// Assumes tick_1hz is a single-cycle pulse synchronous to clk and that
// software writes only valid BCD values.
module rtc_dbuf_clock
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              pwr_fail,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_oe
);

    logic [NUM_FIELDS-1:0] time_ld;
    logic                  ctrl_wr;
    logic                  freeze_q;
    time_vec_t             cnt_q;
    time_vec_t             cnt_nxt;
    time_vec_t             vis_q;

    // Freeze control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       freeze_q <= 1'b0;
        else if (ctrl_wr) freeze_q <= wdata[FREEZE_BIT];
    end

    rtc_bus_port #(.ADDR_W(ADDR_W)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .cs       (cs),
        .we       (we),
        .addr     (addr),
        .vis      (vis_q),
        .freeze   (freeze_q),
        .time_ld  (time_ld),
        .ctrl_wr  (ctrl_wr),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    rtc_time_chain u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .ld_en  (time_ld),
        .ld_val (wdata),
        .cur    (cnt_q),
        .nxt    (cnt_nxt)
    );

    rtc_shadow_regs u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .freeze  (freeze_q),
        .ld_en   (time_ld),
        .ld_val  (wdata),
        .cnt_nxt (cnt_nxt),
        .vis     (vis_q)
    );

endmodule

// File: rtl/rtc_dbuf_clock_checker.sv
// Checker bound to the clock top: relates the freeze bit, the visible copy,
// the counters and the bus outputs over time.
module rtc_dbuf_clock_checker
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1hz,
    input  logic                  pwr_fail,
    input  logic                  freeze_q,
    input  logic [NUM_FIELDS-1:0] time_ld,
    input  time_vec_t             vis_q,
    input  time_vec_t             cnt_q,
    input  logic [7:0]            rdata,
    input  logic                  rdata_oe
);

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !(|time_ld)) |=> $stable(vis_q));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_q |=> (vis_q == cnt_q));

    assert_pf_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!rdata_oe && rdata == 8'h00));

    assert_pf_noload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> (time_ld == '0));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !(|time_ld)) |=> $stable(cnt_q));

    assert_clock_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[FLD_SEC] <= 8'h59) && (cnt_q[FLD_MIN] <= 8'h59) && (cnt_q[FLD_HOUR] <= 8'h23));

    assert_date_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[FLD_DATE] >= 8'h01) && (cnt_q[FLD_DATE] <= month_len(cnt_q[FLD_MON], cnt_q[FLD_YEAR])));

    assert_dow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[FLD_DOW] >= 8'h01) && (cnt_q[FLD_DOW] <= 8'h07));

endmodule

bind rtc_dbuf_clock rtc_dbuf_clock_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .pwr_fail (pwr_fail),
    .freeze_q (freeze_q),
    .time_ld  (time_ld),
    .vis_q    (vis_q),
    .cnt_q    (cnt_q),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
);

// File: tb/rtc_dbuf_clock_bench.sv
// Bench: behavioural calendar model stepped on every edge, compared with
// the bus outputs on every falling edge.
module rtc_dbuf_clock_bench;

    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_1hz = 1'b0;
    logic              pwr_fail = 1'b0;
    logic              cs = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              rdata_oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    checking = 1'b0;
    string cur_req = "R1";

    int  im [7];
    int  vm [7];
    bit  mhalt;
    bit  exp_oe;
    logic [7:0] exp_rd;

    always #5 clk = ~clk;

    rtc_dbuf_clock #(.ADDR_W(ADDR_W)) u_rtc_dbuf_clock (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_fail(pwr_fail),
        .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mdays(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [ADDR_W-1:0] reg_addr(input int off);
        return {{(ADDR_W-3){1'b1}}, 3'(off)};
    endfunction

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            im = '{0, 0, 0, 1, 1, 1, 0};
            vm = im;
            mhalt = 0;
            exp_oe = 0;
            exp_rd = 8'h00;
        end else begin
            bit hit, acc, oldh;
            int off, md;
            hit = &addr[ADDR_W-1:3];
            off = int'(addr[2:0]);
            acc = cs && hit && !pwr_fail;
            oldh = mhalt;
            if (acc && !we) begin
                exp_oe = 1;
                exp_rd = (off == 0) ? (mhalt ? 8'h40 : 8'h00) : to_bcd(vm[off-1]);
            end else begin
                exp_oe = 0;
                exp_rd = 8'h00;
            end
            if (tick_1hz) begin
                md = mdays(im[5], im[6]);
                im[0]++;
                if (im[0] == 60) begin
                    im[0] = 0; im[1]++;
                    if (im[1] == 60) begin
                        im[1] = 0; im[2]++;
                        if (im[2] == 24) begin
                            im[2] = 0;
                            im[3] = (im[3] == 7) ? 1 : im[3] + 1;
                            if (im[4] == md) begin
                                im[4] = 1; im[5]++;
                                if (im[5] == 13) begin
                                    im[5] = 1;
                                    im[6] = (im[6] == 99) ? 0 : im[6] + 1;
                                end
                            end else im[4]++;
                        end
                    end
                end
            end
            if (acc && we && off != 0) im[off-1] = from_bcd(wdata);
            if (!oldh) vm = im;
            else if (acc && we && off != 0) vm[off-1] = from_bcd(wdata);
            if (acc && we && off == 0) mhalt = wdata[6];
        end
    end

    // Compare bus outputs with the model on every clock.
    always @(negedge clk) begin
        if (checking) begin
            n_cmp++;
            if (rdata_oe !== exp_oe || rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s: oe=%0b rdata=%02h expected oe=%0b rdata=%02h",
                         cur_req, rdata_oe, rdata, exp_oe, exp_rd);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cyc(input bit t, input bit c, input bit w,
                       input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        tick_1hz = t; cs = c; we = w; addr = a; wdata = d;
    endtask

    task automatic nop();       cyc(0, 0, 0, '0, 8'h00); endtask
    task automatic tk();        cyc(1, 0, 0, '0, 8'h00); endtask
    task automatic wr(input int off, input logic [7:0] d); cyc(0, 1, 1, reg_addr(off), d); endtask
    task automatic rd(input int off); cyc(0, 1, 0, reg_addr(off), 8'h00); endtask

    task automatic rd_all();
        for (int o = 0; o < 8; o++) rd(o);
        nop();
    endtask

    task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                            input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mi,
                            input logic [7:0] se);
        wr(7, yr); wr(6, mo); wr(5, dt); wr(4, dw); wr(3, hr); wr(2, mi); wr(1, se);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;

        cur_req = "R1";   // reset state and register map
        rd_all();

        cur_req = "R11";  // read latency and out-of-range address
        cyc(0, 1, 0, 17'h0_0005, 8'h00);
        cyc(0, 1, 0, {2'b10, 15'h7FFF}, 8'h00);
        nop();

        cur_req = "R2";   // plain counting and minute/hour carries
        for (int i = 0; i < 65; i++) begin tk(); if (i % 16 == 0) rd(1); end
        rd_all();
        set_time(8'h23, 8'h06, 8'h15, 8'h03, 8'h22, 8'h59, 8'h58);
        for (int i = 0; i < 3; i++) begin tk(); rd_all(); end

        cur_req = "R3";   // month lengths and leap years
        set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59); tk(); rd_all();
        set_time(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59); tk(); rd_all();
        tk(); rd_all();
        set_time(8'h24, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59); tk(); rd_all();
        set_time(8'h31, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59); tk(); rd_all();
        set_time(8'h30, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59); tk(); rd_all();
        set_time(8'h42, 8'h01, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); tk(); rd_all();

        cur_req = "R4";   // day of week wrap
        set_time(8'h42, 8'h03, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59); tk(); rd_all();

        cur_req = "R10";  // full carry through every field
        set_time(8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59); tk(); rd_all();

        cur_req = "R5";   // freeze holds visible copy
        set_time(8'h10, 8'h07, 8'h04, 8'h02, 8'h12, 8'h30, 8'h55);
        tk(); wr(0, 8'h40); rd_all();
        for (int i = 0; i < 8; i++) tk();
        rd_all();
        wr(2, 8'h45); rd_all();

        cur_req = "R6";   // counting continued underneath; release
        wr(0, 8'h00); rd_all();

        cur_req = "R7";   // release collides with a carrying tick
        wr(1, 8'h59); wr(0, 8'h40); tk(); tk();
        cyc(1, 1, 1, reg_addr(0), 8'h00);
        rd_all();

        cur_req = "R9";   // write collides with a carrying tick
        wr(1, 8'h59);
        cyc(1, 1, 1, reg_addr(1), 8'h20);
        rd_all();
        wr(2, 8'h59); wr(1, 8'h59);
        cyc(1, 1, 1, reg_addr(2), 8'h10);
        rd_all();

        cur_req = "R8";   // power-fail isolation
        pwr_fail = 1'b1;
        wr(1, 8'h11); wr(0, 8'h40); rd(1); rd(0); tk(); rd(7);
        nop();
        pwr_fail = 1'b0;
        nop();
        rd_all();

        repeat (3) nop();
        checking = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule